// File: doc/BRIEF.md
# Fifth-Order One-Bit Noise-Shaping Modulator

This block turns signed PCM samples, already brought up to the oversampled rate (for example 64 × 44.1 kHz, about 2.82 MHz), into a one-bit pulse-density stream. The stream's running density of ones follows the input level. The quantization noise is pushed out of the audio band by a fifth-order loop. The loop is a chain of five integrators. Each integrator output is weighted by a power of two, and the weighted sum is quantized to one bit.

Two features keep the loop stable:
- Small leaky feedback terms, each a power-of-two fraction, go from stages 2, 4 and 5 back into the stage before each of them.
- An overload watch on stage 2 clears the three upper integrators when that stage leaves a safe range.

The datapath has only adders and arithmetic shifts. It has no multipliers.

Each sample is presented with a valid strobe. The matching output bit appears one clock later with its own valid strobe. Between strobes the whole loop holds its state.

Top module: `sdm5_modulator`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, all five integrators clear and `pdm_bit` and `pdm_valid` are 0 after that edge.
- R2: `pdm_valid` is 1 in exactly the cycle after each clock edge at which `pcm_valid` was 1, and 0 otherwise.
- R3: A clock edge with `pcm_valid` low changes neither `pdm_bit` nor any integrator. The bit sequence produced for a run of samples therefore does not depend on gaps between them.
- R4: The output bit is 1 when S is zero or positive and 0 when S is negative. S is the signed sum of the updated integrators I1..I5 shifted left by 9, 8, 6, 3 and 0 bits respectively.
- R5: Stage 1 adds the sign-extended input and subtracts a full-scale feedback value: +32767 when the previous output bit was 1, and −32768 when it was 0. So after reset with a zero input, the first output bit is 1.
- R6: Stages 2 to 5 each add the previous value of the stage below. Stage 1 also subtracts I2 arithmetically shifted right by 10. Stage 3 subtracts I4 shifted right by 9. Stage 4 subtracts I5 shifted right by 9. Integrators are 40-bit two's complement and wrap.
- R7: When the updated I2 is above 65534 or below −65536, the updated I3, I4 and I5 are replaced by 0 before storing and before forming S.
- R8: For a constant input x, the density of ones over 2048 samples is within 0.03 of (x + 32768) / 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcm_in | input | 16 | Signed PCM sample |
| pcm_valid | input | 1 | Sample strobe; loop advances only when high |
| pdm_bit | output | 1 | Registered one-bit output |
| pdm_valid | output | 1 | High the cycle after an accepted sample |

## Verification
The bench compares every output against a behavioural model, using four kinds of input:
- **Constant inputs at several levels.** These separate a correct density from a wrong feedback sign or full-scale value.
- **A large triangle wave.** This stresses the weighted sum and the leak shifts, where a wrong shift amount shows as a diverging bitstream.
- **Full-scale plateaus.** These drive stage 2 toward its limits, so a missing or misplaced overload clear makes the output diverge.
- **Random gaps in the sample strobe.** These show whether idle cycles disturb the loop.

A reset in the middle of a run checks that the state is fully cleared.

// File: rtl/sdm5_pkg.sv
// Package: shared constants of the fifth-order modulator.
// Assumes five stages; shift amounts are fixed by the loop design.
package sdm5_pkg;
    localparam int NSTAGE  = 5;
    localparam int LEAK_S2 = 10;  // stage-2 leak into stage 1
    localparam int LEAK_S4 = 9;   // stage-4 leak into stage 3
    localparam int LEAK_S5 = 9;   // stage-5 leak into stage 4

    // Output weight of stage k (0-based) as a left-shift count.
    function automatic int ff_shift(input int k);
        case (k)
            0:       return 9;
            1:       return 8;
            2:       return 6;
            3:       return 3;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/sdm5_integ.sv
// Module: one loop integrator register.
// Loads the precomputed next value when enabled; holds otherwise.
// Assumes the caller has already applied any overload clear to d_next.
module sdm5_integ #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d_next,
    output logic [W-1:0] q
);
    // State register: clear on reset, update on accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d_next;
    end

    AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R3
endmodule

// File: rtl/sdm5_quant.sv
// Module: weighted feed-forward summer and one-bit quantizer.
// Sums the stored-to-be integrator values with power-of-two weights,
// registers the sign as the output bit. Assumes SW leaves headroom
// so the sum never wraps.
module sdm5_quant
    import sdm5_pkg::*;
#(
    parameter int W  = 40,
    parameter int SW = W + 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [NSTAGE-1:0][W-1:0] st,
    output logic                   bit_q,
    output logic                   vld_q
);
    logic signed [SW-1:0] term [NSTAGE];
    logic signed [SW-1:0] wsum;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_term
        assign term[k] = $signed({{(SW-W){st[k][W-1]}}, st[k]}) <<< ff_shift(k);
    end

    // Adder tree for the weighted sum.
    always_comb begin
        wsum = '0;
        for (int k = 0; k < NSTAGE; k++) wsum = wsum + term[k];
    end

    // Output register: bit is 1 for non-negative sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= en;
            if (en) bit_q <= ~wsum[SW-1];
        end
    end

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(bit_q)); // R3
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> vld_q); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !vld_q); // R2
endmodule

// File: rtl/sdm5_modulator.sv
// Module: fifth-order single-bit noise-shaping modulator (top).
// Computes next integrator values with shift-only leaks and full-scale
// one-bit feedback, applies the stage-2 overload clear, and hands the
// results to the integrators and the quantizer. Assumes W >= IN_W + 20.
module sdm5_modulator
    import sdm5_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int W    = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] pcm_in,
    input  logic            pcm_valid,
    output logic            pdm_bit,
    output logic            pdm_valid
);
    localparam longint FS_POS  = (64'sd1 <<< (IN_W-1)) - 1;
    localparam longint FS_NEG  = -(64'sd1 <<< (IN_W-1));
    localparam logic signed [W-1:0] FB_POS = W'(FS_POS);
    localparam logic signed [W-1:0] FB_NEG = W'(FS_NEG);
    localparam logic signed [W-1:0] OVL_HI = W'(2 * FS_POS);
    localparam logic signed [W-1:0] OVL_LO = W'(2 * FS_NEG);

    logic [W-1:0]          acc  [NSTAGE];
    logic signed [W-1:0]   a    [NSTAGE];
    logic signed [W-1:0]   nxt  [NSTAGE];
    logic signed [W-1:0]   post [NSTAGE];
    logic [NSTAGE-1:0][W-1:0] post_pk;
    logic signed [W-1:0]   x_ext;
    logic signed [W-1:0]   fb;
    logic                  ovl;

    // Loop difference equations on the current state.
    always_comb begin
        for (int k = 0; k < NSTAGE; k++) a[k] = $signed(acc[k]);
        x_ext  = $signed({{(W-IN_W){pcm_in[IN_W-1]}}, pcm_in});
        fb     = pdm_bit ? FB_POS : FB_NEG;
        nxt[0] = a[0] + x_ext - fb - (a[1] >>> LEAK_S2);
        nxt[1] = a[1] + a[0];
        nxt[2] = a[2] + a[1] - (a[3] >>> LEAK_S4);
        nxt[3] = a[3] + a[2] - (a[4] >>> LEAK_S5);
        nxt[4] = a[4] + a[3];
    end

    // Overload watch on stage 2 and clear of the upper stages.
    always_comb begin
        ovl = (nxt[1] > OVL_HI) || (nxt[1] < OVL_LO);
        for (int k = 0; k < NSTAGE; k++) begin
            post[k]    = (k >= 2 && ovl) ? '0 : nxt[k];
            post_pk[k] = post[k];
        end
    end

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        sdm5_integ #(.W(W)) u_integ (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (pcm_valid),
            .d_next (post[k]),
            .q      (acc[k])
        );
    end

    sdm5_quant #(.W(W), .SW(W + 12)) u_quant (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pcm_valid),
        .st    (post_pk),
        .bit_q (pdm_bit),
        .vld_q (pdm_valid)
    );

    AST_OVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid && ovl) |=> (acc[2] == '0 && acc[3] == '0 && acc[4] == '0)); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!pdm_bit && !pdm_valid && acc[0] == '0 && acc[1] == '0)); // R1
endmodule

// File: tb/sdm5_modulator_tb.sv
module sdm5_modulator_tb;
    localparam int W    = 40;
    localparam int IN_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IN_W-1:0] pcm = '0;
    logic            vld = 1'b0;
    logic            pdm_bit, pdm_valid;

    int     errors = 0, checks = 0, ones = 0;
    bit     done = 0;
    longint m [5];
    int     mbit = 0, exp_valid = 0;

    always #10 clk = ~clk;

    sdm5_modulator #(.IN_W(IN_W), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pcm_in(pcm), .pcm_valid(vld),
        .pdm_bit(pdm_bit), .pdm_valid(pdm_valid)
    );

    function automatic longint wrapw(input longint v);
        return (v <<< (64 - W)) >>> (64 - W);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 5; k++) m[k] = 0;
        mbit = 0;
        exp_valid = 0;
    endtask

    // Behavioural reference: one accepted sample.
    task automatic model_step(input longint x);
        longint n [5];
        longint fbv, s;
        fbv  = (mbit != 0) ? 64'sd32767 : -64'sd32768;
        n[0] = wrapw(m[0] + x - fbv - (m[1] >>> 10));
        n[1] = wrapw(m[1] + m[0]);
        n[2] = wrapw(m[2] + m[1] - (m[3] >>> 9));
        n[3] = wrapw(m[3] + m[2] - (m[4] >>> 9));
        n[4] = wrapw(m[4] + m[3]);
        if (n[1] > 65534 || n[1] < -65536) begin
            n[2] = 0; n[3] = 0; n[4] = 0;
        end
        for (int k = 0; k < 5; k++) m[k] = n[k];
        s = (n[0] <<< 9) + (n[1] <<< 8) + (n[2] <<< 6) + (n[3] <<< 3) + n[4];
        mbit = (s >= 0) ? 1 : 0;
    endtask

    // Compare outputs of the previous cycle, then drive the next one.
    task automatic apply(input logic v, input longint x);
        @(negedge clk);
        check("R2 valid", longint'(pdm_valid), longint'(exp_valid));
        check("R4 bit (loop R5 R6 R7, hold R3)", longint'(pdm_bit), longint'(mbit));
        if (pdm_valid) ones += pdm_bit;
        pcm = IN_W'(x);
        vld = v;
        if (v) model_step(x);
        exp_valid = v;
    endtask

    task automatic density(input longint x);
        int  p1000, e1000;
        apply(0, 0);
        ones = 0;
        for (int i = 0; i < 2048; i++) apply(1, x);
        apply(0, 0);
        p1000 = (ones * 1000) / 2048;
        e1000 = int'(((x + 32768) * 1000) / 65535);
        checks++;
        if (p1000 > e1000 + 30 || p1000 < e1000 - 30) begin
            errors++;
            $display("FAIL R8 density x=%0d actual=%0d/1000 expected=%0d/1000", x, p1000, e1000);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vld   = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset bit", longint'(pdm_bit), 0);
        check("R1 reset valid", longint'(pdm_valid), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R5: first bit after reset with zero input must be 1.
        apply(1, 0);
        apply(0, 0);
        check("R5 first bit after reset", longint'(pdm_bit), 1);
        // R8: constant levels.
        density(0);
        density(16000);
        density(-20000);
        // R4 R6: large triangle wave.
        for (int i = 0; i < 1200; i++) begin
            int ph;
            ph = i % 200;
            apply(1, (ph < 100) ? (-30000 + ph * 600) : (30000 - (ph - 100) * 600));
        end
        // R7: full-scale plateaus drive stage 2 to its limits.
        for (int i = 0; i < 600; i++) apply(1, 32767);
        for (int i = 0; i < 600; i++) apply(1, -32768);
        for (int i = 0; i < 300; i++) apply(1, (i % 2) ? 32767 : -32768);
        // R3: random gaps in the strobe.
        for (int i = 0; i < 2000; i++)
            apply(($urandom % 4) != 0, longint'($signed(16'($urandom))) / 2);
        // R1: reset mid-run, then the state must be fresh again.
        do_reset();
        apply(1, 0);
        apply(0, 0);
        check("R1 state cleared (first bit 1)", longint'(pdm_bit), 1);
        for (int i = 0; i < 200; i++) apply(1, 5000);
        apply(0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule